// File: doc/BRIEF.md
# Sparse Circulant Vector Multiplier

This block multiplies a length-P vector `v` by a sparse P×P circulant matrix. The matrix is described only by the column positions of the nonzero entries in its first row. Each listed position `x` adds one cyclically rotated copy of `v` to the result: result element `j` receives `v[(x + j) mod P]`. The vector lives in an external memory organised as `W = ceil(P/NB)` words of `NB` consecutive elements. The result is built up in an external memory of the same shape, through one read port and one write port.

After a start pulse the block clears every result word. It then walks the position list. For each position it streams the rotated copy of `v` one word at a time. A two-row element window re-aligns the stream to word boundaries. Elements below the start index in the first word are held back and appended last, which closes the wrap-around without reading the first word again. Each aligned word is merged into the stored result by read-modify-write. In binary mode the merge is a per-element modulo-2 sum. In integer mode it is an unsigned add that saturates.

Top module: `sparse_circ_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `pos_rd`, `v_rd`, `r_rd` and `r_wr` are all low.
- R2: A start pulse seen while idle writes zero to every one of the W result words before any accumulation takes place. With an empty position list (`num_pos` = 0), the result memory therefore ends all zero.
- R3: With `mode` = 0 (binary), result element j holds, in bit 0, the XOR of bit 0 of `v[(x+j) mod P]` over all listed positions x. Its upper bits are zero, so a position listed twice cancels.
- R4: With `mode` = 1 (integer), result element j is the unsigned sum of `v[(x+j) mod P]` over all listed positions, clamped at 2^EW−1.
- R5: When P is not a multiple of NB, the rotated copy wraps from element P−1 to element 0. It never takes data from the padding lanes of the last v word, and the padding lanes of the last result word end at zero. Element e sits in word e/NB, lane e mod NB, at bits [lane*EW +: EW].
- R6: For each position the block reads exactly W words of v. The first of these reads is at word floor(x/NB), and the following reads go to ascending addresses modulo W. Position entries are read from address 0 up to `num_pos`−1.
- R7: `done` is high for exactly one cycle, in the cycle after the last result write of the run. With an empty list, that last write is the final clearing write.
- R8: A start pulse while a run is in progress is ignored. The running mode and position count are kept.
- R9: Every result read is followed in the next cycle by a write to the same word. In any cycle at most one of `pos_rd`, `v_rd`, `r_rd` is high. All memories return read data in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when idle |
| mode | input | 1 | 0 binary, 1 saturating integer; sampled at start |
| num_pos | input | PCW | Number of listed positions, sampled at start |
| done | output | 1 | One-cycle completion pulse |
| pos_rd | output | 1 | Position list read strobe |
| pos_addr | output | PAW | Position list address |
| pos_data | input | XW | Position value, valid the cycle after `pos_rd` |
| v_rd | output | 1 | Vector memory read strobe |
| v_addr | output | WAW | Vector word address |
| v_rdata | input | NB*EW | Vector word, valid the cycle after `v_rd` |
| r_rd | output | 1 | Result memory read strobe |
| r_raddr | output | WAW | Result read word address |
| r_rdata | input | NB*EW | Result word, valid the cycle after `r_rd` |
| r_wr | output | 1 | Result memory write strobe |
| r_waddr | output | WAW | Result write word address |
| r_wdata | output | NB*EW | Result write data |

## Verification
The bench builds the block with P=15, NB=4, EW=4 and up to 8 positions. A length that is not a multiple of the word size makes the last word three elements wide, so every start position meets the partial-word wrap and the padding lanes. The padding lanes of the v memory are filled with random values, so any leak of padding data into the result would show. A 4-bit element width lets eight summed copies pass the clamp value, and starts in every lane of every word, including the last partial one, come within reach of the random runs.

// File: rtl/cvm_pkg.sv
package cvm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_POSRD,
        ST_POSWAIT,
        ST_VRD,
        ST_VAPP,
        ST_HOLD,
        ST_RMW,
        ST_DONE
    } cvm_state_e;

    localparam logic MODE_BIN = 1'b0;
    localparam logic MODE_INT = 1'b1;

endpackage

// File: rtl/cvm_window.sv
// Two-row element window: appends a lane range of a word behind the
// current fill level, or pops the oldest NB elements as one aligned word.
module cvm_window #(
    parameter int NB = 4,
    parameter int EW = 8,
    parameter int CW = 4,
    parameter int LW = 3
) (
    input  logic [2*NB-1:0][EW-1:0] win_q,
    input  logic [CW-1:0]           cnt_q,
    input  logic                    app_en,
    input  logic [NB-1:0][EW-1:0]   app_word,
    input  logic [LW-1:0]           app_lo,
    input  logic [LW-1:0]           app_hi,
    input  logic                    pop_en,
    output logic [2*NB-1:0][EW-1:0] win_d,
    output logic [CW-1:0]           cnt_d,
    output logic [NB-1:0][EW-1:0]   head
);
    localparam int LNB = $clog2(NB);

    // oldest NB elements, lanes beyond the fill level read as zero
    for (genvar j = 0; j < NB; j++) begin : g_head
        assign head[j] = (CW'(j) < cnt_q) ? win_q[j] : '0;
    end

    always_comb begin
        win_d = win_q;
        cnt_d = cnt_q;
        if (pop_en) begin
            for (int t = 0; t < NB; t++) begin
                win_d[t] = win_q[t+NB];
            end
            for (int t = NB; t < 2*NB; t++) begin
                win_d[t] = '0;
            end
            cnt_d = (cnt_q >= CW'(NB)) ? cnt_q - CW'(NB) : '0;
        end else if (app_en) begin
            for (int t = 0; t < 2*NB; t++) begin
                automatic int off = t - int'(cnt_q);
                automatic int len = int'(app_hi) - int'(app_lo);
                automatic int src = int'(app_lo) + off;
                if (off >= 0 && off < len && src < NB) begin
                    win_d[t] = app_word[src[LNB-1:0]];
                end
            end
            cnt_d = cnt_q + CW'(app_hi - app_lo);
        end
    end

endmodule

// File: rtl/cvm_combine.sv
// Per-lane merge of a stored result word with an aligned vector word.
module cvm_combine #(
    parameter int NB = 4,
    parameter int EW = 8
) (
    input  logic                  int_mode,
    input  logic [NB-1:0][EW-1:0] acc,
    input  logic [NB-1:0][EW-1:0] add,
    output logic [NB-1:0][EW-1:0] sum
);
    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [EW:0]   wide;
        logic [EW-1:0] sat;
        logic [EW-1:0] par;
        assign wide = {1'b0, acc[j]} + {1'b0, add[j]};
        assign sat  = wide[EW] ? {EW{1'b1}} : wide[EW-1:0];
        assign par  = {{(EW-1){1'b0}}, acc[j][0] ^ add[j][0]};
        assign sum[j] = int_mode ? sat : par;
    end

endmodule

// File: rtl/sparse_circ_mul.sv
module sparse_circ_mul
    import cvm_pkg::*;
#(
    parameter int P      = 15,
    parameter int NB     = 4,
    parameter int EW     = 8,
    parameter int MAXPOS = 8,
    localparam int W     = (P + NB - 1) / NB,
    localparam int WAW   = (W > 1) ? $clog2(W) : 1,
    localparam int XW    = $clog2(P),
    localparam int PAW   = (MAXPOS > 1) ? $clog2(MAXPOS) : 1,
    localparam int PCW   = $clog2(MAXPOS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [PCW-1:0]     num_pos,
    output logic               done,
    output logic               pos_rd,
    output logic [PAW-1:0]     pos_addr,
    input  logic [XW-1:0]      pos_data,
    output logic               v_rd,
    output logic [WAW-1:0]     v_addr,
    input  logic [NB*EW-1:0]   v_rdata,
    output logic               r_rd,
    output logic [WAW-1:0]     r_raddr,
    input  logic [NB*EW-1:0]   r_rdata,
    output logic               r_wr,
    output logic [WAW-1:0]     r_waddr,
    output logic [NB*EW-1:0]   r_wdata
);
    localparam int LNB   = $clog2(NB);
    localparam int LW    = $clog2(NB + 1);
    localparam int CW    = $clog2(2*NB + 1);
    localparam int RCW   = $clog2(W + 1);
    localparam int LASTV = P - (W - 1) * NB;

    typedef struct packed {
        cvm_state_e               st;
        logic                     mode;
        logic [PCW-1:0]           npos;
        logic [PCW-1:0]           pidx;
        logic [WAW-1:0]           waddr;
        logic [RCW-1:0]           rdcnt;
        logic [LNB-1:0]           idx;
        logic                     hold_done;
        logic [NB-1:0][EW-1:0]    hold;
        logic [2*NB-1:0][EW-1:0]  win;
        logic [CW-1:0]            cnt;
        logic [RCW-1:0]           kout;
    } ctl_t;

    ctl_t q, d;

    // window and merge datapath
    logic                    app_en_d, pop_en_d;
    logic [NB-1:0][EW-1:0]   app_word_d;
    logic [LW-1:0]           app_lo_d, app_hi_d;
    logic [2*NB-1:0][EW-1:0] win_nx;
    logic [CW-1:0]           cnt_nx;
    logic [NB-1:0][EW-1:0]   head_w;
    logic [NB-1:0][EW-1:0]   acc_w, sum_w;
    logic [PCW-1:0]          npos_lat;

    assign acc_w    = r_rdata;
    assign npos_lat = q.npos;

    cvm_window #(.NB(NB), .EW(EW), .CW(CW), .LW(LW)) u_window (
        .win_q    (q.win),
        .cnt_q    (q.cnt),
        .app_en   (app_en_d),
        .app_word (app_word_d),
        .app_lo   (app_lo_d),
        .app_hi   (app_hi_d),
        .pop_en   (pop_en_d),
        .win_d    (win_nx),
        .cnt_d    (cnt_nx),
        .head     (head_w)
    );

    cvm_combine #(.NB(NB), .EW(EW)) u_combine (
        .int_mode (q.mode == MODE_INT),
        .acc      (acc_w),
        .add      (head_w),
        .sum      (sum_w)
    );

    always_comb begin
        logic                  decide;
        logic [XW+LNB-1:0]     xe;
        logic                  stream_end;

        d          = q;
        decide     = 1'b0;
        xe         = {{LNB{1'b0}}, pos_data};
        stream_end = 1'b0;

        done       = 1'b0;
        pos_rd     = 1'b0;
        pos_addr   = q.pidx[PAW-1:0];
        v_rd       = 1'b0;
        v_addr     = q.waddr;
        r_rd       = 1'b0;
        r_raddr    = WAW'(q.kout);
        r_wr       = 1'b0;
        r_waddr    = WAW'(q.kout);
        r_wdata    = '0;
        app_en_d   = 1'b0;
        pop_en_d   = 1'b0;
        app_word_d = v_rdata;
        app_lo_d   = '0;
        app_hi_d   = '0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mode = mode;
                    d.npos = num_pos;
                    d.kout = '0;
                    d.st   = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                r_wr = 1'b1;
                if (q.kout == RCW'(W - 1)) begin
                    d.kout = '0;
                    d.pidx = '0;
                    d.st   = (q.npos == '0) ? ST_DONE : ST_POSRD;
                end else begin
                    d.kout = q.kout + 1'b1;
                end
            end
            ST_POSRD: begin
                pos_rd = 1'b1;
                d.st   = ST_POSWAIT;
            end
            ST_POSWAIT: begin
                d.waddr     = WAW'(xe >> LNB);
                d.idx       = xe[LNB-1:0];
                d.rdcnt     = '0;
                d.cnt       = '0;
                d.kout      = '0;
                d.hold_done = 1'b0;
                d.st        = ST_VRD;
            end
            ST_VRD: begin
                v_rd = 1'b1;
                d.st = ST_VAPP;
            end
            ST_VAPP: begin
                app_en_d   = 1'b1;
                app_word_d = v_rdata;
                app_lo_d   = (q.rdcnt == '0) ? LW'(q.idx) : '0;
                app_hi_d   = (q.waddr == WAW'(W - 1)) ? LW'(LASTV) : LW'(NB);
                if (q.rdcnt == '0) begin
                    d.hold = v_rdata;
                end
                d.rdcnt = q.rdcnt + 1'b1;
                d.waddr = (q.waddr == WAW'(W - 1)) ? '0 : q.waddr + 1'b1;
                decide  = 1'b1;
            end
            ST_HOLD: begin
                app_en_d    = 1'b1;
                app_word_d  = q.hold;
                app_lo_d    = '0;
                app_hi_d    = LW'(q.idx);
                d.hold_done = 1'b1;
                decide      = 1'b1;
            end
            ST_RMW: begin
                pop_en_d = 1'b1;
                r_wr     = 1'b1;
                r_wdata  = sum_w;
                d.kout   = q.kout + 1'b1;
                decide   = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        d.win = win_nx;
        d.cnt = cnt_nx;

        if (decide) begin
            stream_end = (d.rdcnt == RCW'(W)) && (d.hold_done || q.idx == '0);
            if (d.cnt >= CW'(NB) || (stream_end && d.cnt != '0)) begin
                r_rd    = 1'b1;
                r_raddr = WAW'(d.kout);
                d.st    = ST_RMW;
            end else if (d.rdcnt < RCW'(W)) begin
                d.st = ST_VRD;
            end else if (!stream_end) begin
                d.st = ST_HOLD;
            end else begin
                d.pidx = q.pidx + 1'b1;
                d.st   = (d.pidx == q.npos) ? ST_DONE : ST_POSRD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sparse_circ_mul_chk.sv
module sparse_circ_mul_chk #(
    parameter int P      = 15,
    parameter int NB     = 4,
    parameter int MAXPOS = 8,
    localparam int W     = (P + NB - 1) / NB,
    localparam int WAW   = (W > 1) ? $clog2(W) : 1,
    localparam int PAW   = (MAXPOS > 1) ? $clog2(MAXPOS) : 1,
    localparam int PCW   = $clog2(MAXPOS + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done,
    input logic           pos_rd,
    input logic [PAW-1:0] pos_addr,
    input logic           v_rd,
    input logic [WAW-1:0] v_addr,
    input logic           r_rd,
    input logic [WAW-1:0] r_raddr,
    input logic           r_wr,
    input logic [WAW-1:0] r_waddr,
    input logic [PCW-1:0] npos
);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(r_wr))
        else $error("done without a preceding result write");

    assert_rmw_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |=> (r_wr && r_waddr == $past(r_raddr)))
        else $error("result read not followed by write to same word");

    assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pos_rd, v_rd, r_rd}) <= 1)
        else $error("more than one read strobe in a cycle");

    assert_vaddr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        v_rd |-> v_addr <= WAW'(W - 1))
        else $error("vector address out of range");

    assert_waddr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |-> r_waddr <= WAW'(W - 1))
        else $error("result write address out of range");

    assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pos_rd |-> PCW'(pos_addr) < npos)
        else $error("position read beyond list length");

endmodule

bind sparse_circ_mul sparse_circ_mul_chk #(.P(P), .NB(NB), .MAXPOS(MAXPOS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .pos_rd   (pos_rd),
    .pos_addr (pos_addr),
    .v_rd     (v_rd),
    .v_addr   (v_addr),
    .r_rd     (r_rd),
    .r_raddr  (r_raddr),
    .r_wr     (r_wr),
    .r_waddr  (r_waddr),
    .npos     (npos_lat)
);

// File: tb/tb_sparse_circ_mul.sv
module tb_sparse_circ_mul;
    localparam int P      = 15;
    localparam int NB     = 4;
    localparam int EW     = 4;
    localparam int MAXPOS = 8;
    localparam int W      = (P + NB - 1) / NB;
    localparam int WAW    = $clog2(W);
    localparam int PAW    = $clog2(MAXPOS);
    localparam int PCW    = $clog2(MAXPOS + 1);
    localparam int XW     = $clog2(P);
    localparam int EMAX   = (1 << EW) - 1;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start = 1'b0;
    logic               mode = 1'b0;
    logic [PCW-1:0]     num_pos = '0;
    logic               done, pos_rd, v_rd, r_rd, r_wr;
    logic [PAW-1:0]     pos_addr;
    logic [XW-1:0]      pos_data;
    logic [WAW-1:0]     v_addr, r_raddr, r_waddr;
    logic [NB*EW-1:0]   v_rdata, r_rdata, r_wdata;

    always #10 clk = ~clk;

    sparse_circ_mul #(.P(P), .NB(NB), .EW(EW), .MAXPOS(MAXPOS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .num_pos(num_pos),
        .done(done), .pos_rd(pos_rd), .pos_addr(pos_addr), .pos_data(pos_data),
        .v_rd(v_rd), .v_addr(v_addr), .v_rdata(v_rdata),
        .r_rd(r_rd), .r_raddr(r_raddr), .r_rdata(r_rdata),
        .r_wr(r_wr), .r_waddr(r_waddr), .r_wdata(r_wdata)
    );

    // memory models, one-cycle read latency
    logic [XW-1:0]    posmem [MAXPOS];
    logic [NB*EW-1:0] vmem   [W];
    logic [NB*EW-1:0] rmem   [W];
    logic             pre_we = 1'b0;
    logic [WAW-1:0]   pre_addr = '0;
    logic [NB*EW-1:0] pre_data = '0;

    always @(posedge clk) begin
        if (pos_rd) pos_data <= posmem[pos_addr];
        if (v_rd)   v_rdata  <= vmem[v_addr];
        if (r_rd)   r_rdata  <= rmem[r_raddr];
        if (r_wr)   rmem[r_waddr] <= r_wdata;
        else if (pre_we) rmem[pre_addr] <= pre_data;
    end

    int             vrd_total = 0;
    int             cyc = 0;
    logic           arm = 1'b0;
    logic [WAW-1:0] first_va = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (v_rd) vrd_total <= vrd_total + 1;
        if (pos_rd) arm <= 1'b1;
        else if (v_rd && arm) begin
            first_va <= v_addr;
            arm      <= 1'b0;
        end
    end

    int checks = 0;
    int failures = 0;
    int ve [P];
    int pl [MAXPOS];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_elem(input int j, input bit im, input int np);
        int acc = 0;
        for (int k = 0; k < np; k++) begin
            int e = ve[(pl[k] + j) % P];
            if (im) acc = (acc + e > EMAX) ? EMAX : acc + e;
            else    acc = acc ^ (e & 1);
        end
        return acc;
    endfunction

    task automatic run_case(input bit im, input int np, input bit poke);
        int t;
        for (int k = 0; k < np; k++) posmem[k] = XW'(pl[k]);
        for (int w = 0; w < W; w++) begin
            for (int l = 0; l < NB; l++) begin
                int e = w * NB + l;
                vmem[w][l*EW +: EW] = (e < P) ? EW'(ve[e]) : EW'($urandom);
            end
        end
        for (int w = 0; w < W; w++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = WAW'(w); pre_data = (NB*EW)'($urandom);
        end
        @(negedge clk);
        pre_we = 1'b0;
        t = vrd_total;
        start = 1'b1; mode = im; num_pos = PCW'(np);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1; mode = ~im; num_pos = '0;   // R8: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        begin
            int n = 0;
            while (!done && n < 4000) begin
                @(negedge clk);
                n++;
            end
            if (!done) begin
                chk("R7 done timeout", 0, 1);
                return;
            end
        end
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        for (int w = 0; w < W; w++) begin
            int expw = 0;
            for (int l = 0; l < NB; l++) begin
                int e = w * NB + l;
                if (e < P) expw |= exp_elem(e, im, np) << (l * EW);
            end
            if (np == 0)         chk("R2 cleared word", int'(rmem[w]), expw);
            else if (w == W - 1) chk(poke ? "R8/R5 last word" : "R5 last word", int'(rmem[w]), expw);
            else if (im)         chk(poke ? "R8/R4 word" : "R4 word", int'(rmem[w]), expw);
            else                 chk(poke ? "R8/R3 word" : "R3 word", int'(rmem[w]), expw);
        end
        chk("R6 v read count", vrd_total - t, np * W);
        if (np > 0) chk("R6 first v address", int'(first_va), pl[np-1] / NB);
    endtask

    task automatic rand_v();
        for (int e = 0; e < P; e++) ve[e] = int'($urandom % (EMAX + 1));
    endtask

    initial begin
        wait (cyc >= 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", int'({done, pos_rd, v_rd, r_rd, r_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after reset", int'({done, pos_rd, v_rd, r_rd, r_wr}), 0);

        // R3: start 3 rotation, binary
        rand_v(); pl[0] = 3; run_case(1'b0, 1, 1'b0);
        // R3: identity rotation
        rand_v(); pl[0] = 0; run_case(1'b0, 1, 1'b0);
        // R5: start in last partial word
        rand_v(); pl[0] = 14; run_case(1'b0, 1, 1'b0);
        rand_v(); pl[0] = 12; pl[1] = 13; pl[2] = 2; run_case(1'b0, 3, 1'b0);
        // R3: repeated position cancels
        rand_v(); pl[0] = 7; pl[1] = 7; run_case(1'b0, 2, 1'b0);
        // R4: integer sum
        rand_v(); pl[0] = 5; pl[1] = 9; run_case(1'b1, 2, 1'b0);
        // R4: saturation with all elements at maximum
        for (int e = 0; e < P; e++) ve[e] = EMAX;
        for (int k = 0; k < MAXPOS; k++) pl[k] = k;
        run_case(1'b1, MAXPOS, 1'b0);
        // R2/R7: empty list
        run_case(1'b1, 0, 1'b0);
        // R8: start while busy
        rand_v(); pl[0] = 6; pl[1] = 11; pl[2] = 1; run_case(1'b1, 3, 1'b1);
        // random mix
        for (int r = 0; r < 14; r++) begin
            int np = 1 + int'($urandom % MAXPOS);
            rand_v();
            for (int k = 0; k < np; k++) pl[k] = int'($urandom % P);
            run_case(1'($urandom), np, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule